// File: doc/BRIEF.md
# Chained Vector Element Sequencer

This block accepts vector instructions over a valid/ready stream into an in-order queue of four entries. Each cycle it decides which element of which queued instruction enters each of three pipelined function units: one memory unit for loads and stores, one multiplier and one adder. The units are modelled as fixed-latency delay lines that carry only a slot, an element index and a last-element flag. No data moves through this block.

A result element is forwarded to a waiting consumer as soon as it leaves its unit (chaining). A unit serves one instruction at a time. The next instruction on that unit starts in the cycle after the previous one's final element entered, so no dead time overlaps. For every unit the block reports two events each cycle. One marks the element that is entering the unit. The other marks the element that is leaving it. Each event carries the instruction tag, the element index and a last-element flag. A reference timing table can therefore be compared directly against these outputs.

The event outputs are plain strobes with no back-pressure, because the units never stall. The only back-pressure is on the instruction input. An instruction transfers in a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the source holds `cmd_valid` and the payload unchanged.

Top module: `vseq_chain_sequencer`

## Requirements
- R1: Right after reset, `cmd_ready` is 1, and no enter or leave strobe is active on any unit.
- R2: An element that enters a unit in cycle s is reported leaving in cycle s+L−1. L is 10 on unit 0 (memory), 7 on unit 1 (multiplier) and 4 on unit 2 (adder).
- R3: Each instruction's elements enter its unit in index order 0..n−1, one per cycle at most, each as early as its constraints allow. No element enters before the cycle after the instruction was accepted.
- R4: Chaining: element i of a consumer enters no earlier than the cycle after element i of its producer leaves the producer's unit.
- R5: A unit holds one instruction at a time. Element 0 of the next instruction on that unit enters no earlier than the cycle after the previous instruction's last element entered.
- R6: The producer of a source register is the youngest older queued instruction that writes that register. A source with no such instruction in the queue is ready at once.
- R7: `cmd_op` encoding: 0 is load (writes dst, reads nothing), 1 is store (reads src_a only, writes nothing), 2 is multiply, 3 is add (both write dst and read src_a and src_b). Fields an opcode does not use have no effect on timing.
- R8: The queue holds 4 instructions. `cmd_ready` is low while 4 are held.
- R9: The oldest instruction frees its slot in the cycle after its last element leaves. `cmd_ready` rises one cycle after that when the queue was full.
- R10: For a load, a multiply of its result by itself, a multiply of that product by the load result, and a store of the second product, all of length n ≥ 16, the cycles are as follows, relative to the cycle in which the load's first element enters. Entries of first elements: 0, 10, n+10, n+17. Entries of last elements: n−1, n+9, 2n+9, 2n+16. Leaves of last elements: n+8, n+15, 2n+15, 2n+25.
- R11: Each accepted instruction gets a tag equal to its acceptance count modulo 16. Every enter and leave strobe for that instruction carries this tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Queue can take an instruction |
| cmd_op | input | 2 | Opcode (R7) |
| cmd_dst | input | 5 | Destination vector register |
| cmd_src_a | input | 5 | First source vector register |
| cmd_src_b | input | 5 | Second source vector register |
| cmd_len | input | 8 | Vector length, at least 1 |
| enter_valid | output | 3 | Per unit: an element enters this cycle |
| enter_tag | output | 12 | Per unit, 4 bits each: instruction tag |
| enter_idx | output | 24 | Per unit, 8 bits each: element index |
| enter_last | output | 3 | Per unit: entering element is the last one |
| leave_valid | output | 3 | Per unit: an element leaves this cycle |
| leave_tag | output | 12 | Per unit: instruction tag |
| leave_idx | output | 24 | Per unit: element index |
| leave_last | output | 3 | Per unit: leaving element is the last one |

## Verification
The assertions take three things on trust. The source keeps `cmd_valid` and the payload stable while `cmd_ready` is low. Every length is at least 1. A consumer is never longer than its producer, because a missing producer element would hold the consumer back indefinitely. The stimulus respects these by giving all instructions of a batch one shared length. It offers a batch only into a drained queue, so an offer never has to wait, and it mixes directed sequences with seeded random opcodes drawn from a small register set.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_MUL   = 2'd2,
    OP_ADD   = 2'd3
  } vop_e;

  localparam int NUM_UNITS = 3;
  localparam logic [1:0] UNIT_MEM = 2'd0;
  localparam logic [1:0] UNIT_MUL = 2'd1;
  localparam logic [1:0] UNIT_ADD = 2'd2;

  function automatic logic [1:0] unit_of(vop_e op);
    case (op)
      OP_MUL:  return UNIT_MUL;
      OP_ADD:  return UNIT_ADD;
      default: return UNIT_MEM;
    endcase
  endfunction

  function automatic logic reads_a(vop_e op);
    return op != OP_LOAD;
  endfunction

  function automatic logic reads_b(vop_e op);
    return (op == OP_MUL) || (op == OP_ADD);
  endfunction

  function automatic logic writes_dst(vop_e op);
    return op != OP_STORE;
  endfunction
endpackage

// File: rtl/vseq_unit_pipe.sv
module vseq_unit_pipe #(
  parameter int LAT   = 4,
  parameter int PTR_W = 2,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [PTR_W-1:0] in_slot,
  input  logic [LEN_W-1:0] in_idx,
  input  logic             in_last,
  output logic             out_v,
  output logic [PTR_W-1:0] out_slot,
  output logic [LEN_W-1:0] out_idx,
  output logic             out_last
);
  // An element occupies the unit for LAT cycles: the entry cycle plus LAT-1 stages.
  generate
    if (LAT == 1) begin : g_pass
      assign out_v    = in_v;
      assign out_slot = in_slot;
      assign out_idx  = in_idx;
      assign out_last = in_last;
    end else begin : g_stages
      localparam int NST = LAT - 1;
      logic [NST-1:0]   v_q;
      logic [PTR_W-1:0] s_q [NST];
      logic [LEN_W-1:0] i_q [NST];
      logic [NST-1:0]   l_q;

      always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else begin
          v_q[0] <= in_v;
          for (int k = 1; k < NST; k++) v_q[k] <= v_q[k-1];
        end
      end

      always_ff @(posedge clk) begin
        s_q[0] <= in_slot;
        i_q[0] <= in_idx;
        l_q[0] <= in_last;
        for (int k = 1; k < NST; k++) begin
          s_q[k] <= s_q[k-1];
          i_q[k] <= i_q[k-1];
          l_q[k] <= l_q[k-1];
        end
      end

      assign out_v    = v_q[NST-1];
      assign out_slot = s_q[NST-1];
      assign out_idx  = i_q[NST-1];
      assign out_last = l_q[NST-1];
    end
  endgenerate
endmodule

// File: rtl/vseq_issue_pick.sv
module vseq_issue_pick #(
  parameter int         DEPTH = 4,
  parameter int         PTR_W = 2,
  parameter logic [1:0] UNIT  = 2'd0
) (
  input  logic [PTR_W-1:0]   head,
  input  logic [DEPTH-1:0]   pending,
  input  logic [2*DEPTH-1:0] unit_flat,
  input  logic [DEPTH-1:0]   operands_ok,
  output logic               fire,
  output logic [PTR_W-1:0]   slot
);
  // The oldest entry that still has elements to send on this unit owns it;
  // younger entries for the same unit wait even when their operands are ready.
  always_comb begin
    logic             found;
    logic [PTR_W-1:0] s;
    found = 1'b0;
    fire  = 1'b0;
    slot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = head + PTR_W'(k);
      if (!found && pending[s] && (unit_flat[2*s +: 2] == UNIT)) begin
        found = 1'b1;
        slot  = s;
        fire  = operands_ok[s];
      end
    end
  end
endmodule

// File: rtl/vseq_chain_sequencer.sv
module vseq_chain_sequencer
  import vseq_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int REG_W   = 5,
  parameter int LEN_W   = 8,
  parameter int TAG_W   = 4,
  parameter int LAT_MEM = 10,
  parameter int LAT_MUL = 7,
  parameter int LAT_ADD = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [REG_W-1:0]           cmd_dst,
  input  logic [REG_W-1:0]           cmd_src_a,
  input  logic [REG_W-1:0]           cmd_src_b,
  input  logic [LEN_W-1:0]           cmd_len,
  output logic [NUM_UNITS-1:0]       enter_valid,
  output logic [NUM_UNITS*TAG_W-1:0] enter_tag,
  output logic [NUM_UNITS*LEN_W-1:0] enter_idx,
  output logic [NUM_UNITS-1:0]       enter_last,
  output logic [NUM_UNITS-1:0]       leave_valid,
  output logic [NUM_UNITS*TAG_W-1:0] leave_tag,
  output logic [NUM_UNITS*LEN_W-1:0] leave_idx,
  output logic [NUM_UNITS-1:0]       leave_last
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  // Queue storage, a ring from head (oldest) to tail.
  logic [DEPTH-1:0]  vld;
  vop_e              op_q     [DEPTH];
  logic [REG_W-1:0]  dst_q    [DEPTH];
  logic [LEN_W-1:0]  len_q    [DEPTH];
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic [LEN_W-1:0]  sent_cnt [DEPTH];
  logic [LEN_W-1:0]  back_cnt [DEPTH];
  logic [1:0]        dep_v    [DEPTH];
  logic [PTR_W-1:0]  dep_p    [DEPTH][2];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  tag_ctr;

  logic push, retire;
  assign cmd_ready = (count != CNT_W'(DEPTH));
  assign push      = cmd_valid && cmd_ready;
  assign retire    = vld[head] && (back_cnt[head] == len_q[head]);

  // Producer lookup for the incoming instruction: youngest older writer.
  logic [1:0]       new_dep_v;
  logic [PTR_W-1:0] new_dep_p [2];
  always_comb begin
    logic [PTR_W-1:0] s;
    logic [REG_W-1:0] src;
    logic             need;
    for (int j = 0; j < 2; j++) begin
      new_dep_v[j] = 1'b0;
      new_dep_p[j] = '0;
      src  = (j == 0) ? cmd_src_a : cmd_src_b;
      need = (j == 0) ? reads_a(vop_e'(cmd_op)) : reads_b(vop_e'(cmd_op));
      for (int k = 0; k < DEPTH; k++) begin
        s = head + PTR_W'(k);
        if (need && vld[s] && !(retire && s == head) &&
            writes_dst(op_q[s]) && dst_q[s] == src) begin
          new_dep_v[j] = 1'b1;
          new_dep_p[j] = s;
        end
      end
    end
  end

  // Per-entry readiness of the next element to send.
  logic [DEPTH-1:0]   pending, operands_ok;
  logic [2*DEPTH-1:0] unit_flat;
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      pending[e]          = vld[e] && (sent_cnt[e] != len_q[e]);
      unit_flat[2*e +: 2] = unit_of(op_q[e]);
      operands_ok[e]      = 1'b1;
      for (int j = 0; j < 2; j++)
        if (dep_v[e][j] && !(back_cnt[dep_p[e][j]] > sent_cnt[e]))
          operands_ok[e] = 1'b0;
    end
  end

  logic [NUM_UNITS-1:0] fire, x_v, x_last, f_last;
  logic [PTR_W-1:0]     pslot  [NUM_UNITS];
  logic [PTR_W-1:0]     x_slot [NUM_UNITS];
  logic [LEN_W-1:0]     x_idx  [NUM_UNITS];

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int ULAT = (u == 0) ? LAT_MEM : ((u == 1) ? LAT_MUL : LAT_ADD);

      vseq_issue_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W), .UNIT(2'(u))) u_pick (
        .head(head), .pending(pending), .unit_flat(unit_flat),
        .operands_ok(operands_ok), .fire(fire[u]), .slot(pslot[u])
      );

      assign f_last[u] = (sent_cnt[pslot[u]] == len_q[pslot[u]] - LEN_W'(1));

      vseq_unit_pipe #(.LAT(ULAT), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_v(fire[u]), .in_slot(pslot[u]), .in_idx(sent_cnt[pslot[u]]), .in_last(f_last[u]),
        .out_v(x_v[u]), .out_slot(x_slot[u]), .out_idx(x_idx[u]), .out_last(x_last[u])
      );

      assign enter_valid[u]               = fire[u];
      assign enter_tag[u*TAG_W +: TAG_W]  = tag_q[pslot[u]];
      assign enter_idx[u*LEN_W +: LEN_W]  = sent_cnt[pslot[u]];
      assign enter_last[u]                = f_last[u];
      assign leave_valid[u]               = x_v[u];
      assign leave_tag[u*TAG_W +: TAG_W]  = tag_q[x_slot[u]];
      assign leave_idx[u*LEN_W +: LEN_W]  = x_idx[u];
      assign leave_last[u]                = x_last[u];

      // R2
      leave_in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_v[u] |-> (vld[x_slot[u]] && x_idx[u] == back_cnt[x_slot[u]]));

      // R5
      one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[u] && !f_last[u]) |=> (!fire[u] || pslot[u] == $past(pslot[u])));

      // R3
      enter_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire[u] |-> (vld[pslot[u]] && unit_of(op_q[pslot[u]]) == 2'(u)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      tag_ctr <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        sent_cnt[e] <= '0;
        back_cnt[e] <= '0;
        dep_v[e]    <= '0;
        op_q[e]     <= OP_LOAD;
        dst_q[e]    <= '0;
        len_q[e]    <= '0;
        tag_q[e]    <= '0;
        dep_p[e][0] <= '0;
        dep_p[e][1] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++)
        for (int u = 0; u < NUM_UNITS; u++) begin
          if (fire[u] && pslot[u] == PTR_W'(e)) sent_cnt[e] <= sent_cnt[e] + LEN_W'(1);
          if (x_v[u] && x_slot[u] == PTR_W'(e)) back_cnt[e] <= back_cnt[e] + LEN_W'(1);
        end
      if (retire) begin
        vld[head] <= 1'b0;
        head      <= head + PTR_W'(1);
        for (int e = 0; e < DEPTH; e++)
          for (int j = 0; j < 2; j++)
            if (dep_p[e][j] == head) dep_v[e][j] <= 1'b0;
      end
      if (push) begin
        vld[tail]      <= 1'b1;
        op_q[tail]     <= vop_e'(cmd_op);
        dst_q[tail]    <= cmd_dst;
        len_q[tail]    <= cmd_len;
        tag_q[tail]    <= tag_ctr;
        sent_cnt[tail] <= '0;
        back_cnt[tail] <= '0;
        dep_v[tail]    <= new_dep_v;
        dep_p[tail][0] <= new_dep_p[0];
        dep_p[tail][1] <= new_dep_p[1];
        tag_ctr        <= tag_ctr + TAG_W'(1);
        tail           <= tail + PTR_W'(1);
      end
      count <= count + CNT_W'(push) - CNT_W'(retire);
    end
  end

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !vld[tail]);

  // R8
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_dst) &&
      $stable(cmd_src_a) && $stable(cmd_src_b) && $stable(cmd_len)));

  // R9
  retire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (sent_cnt[head] == len_q[head]));
endmodule

// File: tb/sim_vseq_chain_sequencer.sv
module sim_vseq_chain_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int MAXE       = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [4:0]  cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
  logic [7:0]  cmd_len = 8'd1;
  logic [2:0]  enter_valid, enter_last, leave_valid, leave_last;
  logic [11:0] enter_tag, leave_tag;
  logic [23:0] enter_idx, leave_idx;

  vseq_chain_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cmd_len(cmd_len), .enter_valid(enter_valid), .enter_tag(enter_tag),
    .enter_idx(enter_idx), .enter_last(enter_last), .leave_valid(leave_valid),
    .leave_tag(leave_tag), .leave_idx(leave_idx), .leave_last(leave_last)
  );

  int cyc = 0;
  int n_checks = 0, n_errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk)
    if (cyc == WATCHDOG) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run hung actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Batch description
  int b_n, b_len, b_base_tag, seq_tag = 0;
  int b_op [4], b_dst [4], b_sa [4], b_sb [4], b_acc [4];
  int act_en [4][MAXE], act_lv [4][MAXE], exp_en [4][MAXE];
  int stray, last_leaves, rdy_first;
  bit watch_rdy;

  function automatic int lat_of(int op);
    return (op <= 1) ? 10 : ((op == 2) ? 7 : 4);
  endfunction
  function automatic int unit_b(int op);
    return (op <= 1) ? 0 : op - 1;
  endfunction

  // Monitor, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    for (int u = 0; u < 3; u++) begin
      if (enter_valid[u]) begin
        int k, idx;
        k   = (int'(enter_tag[u*4 +: 4]) - b_base_tag) & 15;
        idx = int'(enter_idx[u*8 +: 8]);
        if (k < b_n && idx < MAXE && unit_b(b_op[k]) == u && act_en[k][idx] == -1)
          act_en[k][idx] = cyc;
        else stray++;
      end
      if (leave_valid[u]) begin
        int k, idx;
        k   = (int'(leave_tag[u*4 +: 4]) - b_base_tag) & 15;
        idx = int'(leave_idx[u*8 +: 8]);
        if (k < b_n && idx < MAXE && unit_b(b_op[k]) == u && act_lv[k][idx] == -1)
          act_lv[k][idx] = cyc;
        else stray++;
        if (leave_last[u]) last_leaves++;
      end
    end
    if (watch_rdy && cmd_ready && rdy_first == -1) rdy_first = cyc;
  end

  task automatic set_ins(input int k, input int op, input int dst, input int sa, input int sb);
    b_op[k] = op; b_dst[k] = dst; b_sa[k] = sa; b_sb[k] = sb;
  endtask

  // Expected entry cycles, from the timing rules alone
  task automatic compute_expected();
    for (int k = 0; k < b_n; k++) begin
      int start, pa, pb;
      start = b_acc[k] + 1;
      pa = -1; pb = -1;
      for (int j = 0; j < k; j++) begin
        if (unit_b(b_op[j]) == unit_b(b_op[k]) && exp_en[j][b_len-1] + 1 > start)
          start = exp_en[j][b_len-1] + 1;
        if (b_op[j] != 1 && b_op[k] != 0 && b_dst[j] == b_sa[k]) pa = j;
        if (b_op[j] != 1 && b_op[k] >= 2 && b_dst[j] == b_sb[k]) pb = j;
      end
      for (int i = 0; i < b_len; i++) begin
        int t;
        t = (i == 0) ? start : exp_en[k][i-1] + 1;
        if (pa >= 0 && exp_en[pa][i] + lat_of(b_op[pa]) > t) t = exp_en[pa][i] + lat_of(b_op[pa]);
        if (pb >= 0 && exp_en[pb][i] + lat_of(b_op[pb]) > t) t = exp_en[pb][i] + lat_of(b_op[pb]);
        exp_en[k][i] = t;
      end
    end
  endtask

  task automatic run_batch(input string req);
    int guard, bad_en, bad_lv;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < MAXE; i++) begin act_en[k][i] = -1; act_lv[k][i] = -1; end
    stray = 0; last_leaves = 0; rdy_first = -1; watch_rdy = 1'b0;
    b_base_tag = seq_tag & 15;
    for (int k = 0; k < b_n; k++) begin
      @(negedge clk);
      check(cmd_ready == 1'b1, "R8", "ready while offering", int'(cmd_ready), 1);
      cmd_valid = 1'b1; cmd_op = 2'(b_op[k]); cmd_dst = 5'(b_dst[k]);
      cmd_src_a = 5'(b_sa[k]); cmd_src_b = 5'(b_sb[k]); cmd_len = 8'(b_len);
      b_acc[k] = cyc;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    watch_rdy = 1'b1;
    if (b_n == 4) check(cmd_ready == 1'b0, "R8", "ready with 4 held", int'(cmd_ready), 0);
    seq_tag += b_n;
    guard = 0;
    while (last_leaves < b_n && guard < 2000) begin @(negedge clk); guard++; end
    repeat (b_n + 3) @(negedge clk);
    compute_expected();
    for (int k = 0; k < b_n; k++) begin
      int l;
      l = lat_of(b_op[k]);
      check(act_en[k][0] == exp_en[k][0], req, $sformatf("ins%0d first enter", k),
            act_en[k][0], exp_en[k][0]);
      check(act_en[k][b_len-1] == exp_en[k][b_len-1], req, $sformatf("ins%0d last enter", k),
            act_en[k][b_len-1], exp_en[k][b_len-1]);
      check(act_lv[k][b_len-1] == exp_en[k][b_len-1] + l - 1, "R2",
            $sformatf("ins%0d last leave", k), act_lv[k][b_len-1], exp_en[k][b_len-1] + l - 1);
      bad_en = 0; bad_lv = 0;
      for (int i = 0; i < b_len; i++) begin
        if (act_en[k][i] != exp_en[k][i]) bad_en++;
        if (act_lv[k][i] != exp_en[k][i] + l - 1) bad_lv++;
      end
      check(bad_en == 0, "R3", $sformatf("ins%0d element entries off", k), bad_en, 0);
      check(bad_lv == 0, "R2", $sformatf("ins%0d element leaves off", k), bad_lv, 0);
    end
    check(stray == 0, "R11", "strobes with wrong tag, unit or repeat", stray, 0);
  endtask

  initial begin
    int t0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    check(enter_valid == 3'b0 && leave_valid == 3'b0, "R1", "strobes after reset",
          int'({enter_valid, leave_valid}), 0);

    // R10 reference chain, two lengths
    for (int r = 0; r < 2; r++) begin
      n = (r == 0) ? 16 : 20;
      b_n = 4; b_len = n;
      set_ins(0, 0, 1, 0, 0);
      set_ins(1, 2, 2, 1, 1);
      set_ins(2, 2, 3, 2, 1);
      set_ins(3, 1, 0, 3, 0);
      run_batch("R4");
      t0 = act_en[0][0];
      check(act_en[1][0] - t0 == 10,      "R10", "mul1 first enter", act_en[1][0] - t0, 10);
      check(act_en[2][0] - t0 == n + 10,  "R10", "mul2 first enter", act_en[2][0] - t0, n + 10);
      check(act_en[3][0] - t0 == n + 17,  "R10", "store first enter", act_en[3][0] - t0, n + 17);
      check(act_en[0][n-1] - t0 == n - 1, "R10", "load last enter", act_en[0][n-1] - t0, n - 1);
      check(act_en[1][n-1] - t0 == n + 9, "R10", "mul1 last enter", act_en[1][n-1] - t0, n + 9);
      check(act_en[2][n-1] - t0 == 2*n + 9,  "R5", "mul2 last enter", act_en[2][n-1] - t0, 2*n + 9);
      check(act_lv[2][n-1] - t0 == 2*n + 15, "R10", "mul2 last leave", act_lv[2][n-1] - t0, 2*n + 15);
      check(act_lv[3][n-1] - t0 == 2*n + 25, "R10", "store last leave", act_lv[3][n-1] - t0, 2*n + 25);
      check(act_en[0][0] == b_acc[0] + 1, "R3", "load enters after accept", act_en[0][0], b_acc[0] + 1);
    end

    // R7: a load ignores its source fields
    b_n = 2; b_len = 12;
    set_ins(0, 2, 4, 1, 1);
    set_ins(1, 0, 9, 4, 4);
    run_batch("R7");
    check(act_en[1][0] == b_acc[1] + 1, "R7", "load not waiting on src", act_en[1][0], b_acc[1] + 1);

    // R7: a store writes nothing
    b_n = 2; b_len = 9;
    set_ins(0, 1, 2, 1, 1);
    set_ins(1, 3, 5, 2, 2);
    run_batch("R7");
    check(act_en[1][0] == b_acc[1] + 1, "R7", "add not waiting on store", act_en[1][0], b_acc[1] + 1);

    // R6: producer already retired
    b_n = 1; b_len = 8;
    set_ins(0, 0, 5, 0, 0);
    run_batch("R6");
    b_n = 1; b_len = 8;
    set_ins(0, 3, 6, 5, 5);
    run_batch("R6");
    check(act_en[0][0] == b_acc[0] + 1, "R6", "retired producer ignored", act_en[0][0], b_acc[0] + 1);

    // R6: youngest writer is the producer
    b_n = 3; b_len = 10;
    set_ins(0, 0, 1, 0, 0);
    set_ins(1, 0, 1, 0, 0);
    set_ins(2, 3, 2, 1, 1);
    run_batch("R6");
    check(act_en[2][0] == act_en[1][0] + 10, "R6", "add chained on second load",
          act_en[2][0], act_en[1][0] + 10);

    // R8 / R9: fill the queue with serial loads
    b_n = 4; b_len = 20;
    set_ins(0, 0, 1, 0, 0); set_ins(1, 0, 2, 0, 0);
    set_ins(2, 0, 3, 0, 0); set_ins(3, 0, 4, 0, 0);
    run_batch("R5");
    check(rdy_first == act_lv[0][19] + 2, "R9", "ready rises after oldest frees",
          rdy_first, act_lv[0][19] + 2);

    // Length-one corner
    b_n = 2; b_len = 1;
    set_ins(0, 0, 1, 0, 0); set_ins(1, 3, 2, 1, 1);
    run_batch("R4");
    check(act_en[1][0] == act_en[0][0] + 10, "R4", "single element chain",
          act_en[1][0], act_en[0][0] + 10);

    // Seeded random batches
    void'($urandom(32'd4242));
    for (int b = 0; b < 30; b++) begin
      b_n   = 1 + int'($urandom % 4);
      b_len = 1 + int'($urandom % 30);
      for (int k = 0; k < b_n; k++)
        set_ins(k, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
      run_batch("R4 R5 R6");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule